// File: doc/BRIEF.md
# Store Address and Data Formatter

This block sits between the register read stage and the data memory port of a 32-bit big-endian integer core. For each store operation it receives a decoded operation code, the base register value, a flag that says the base register field is zero, an index register value, a 16-bit displacement and the source register value. From these it forms the effective address, the byte-lane enables, the write data placed on the correct lanes, and a request to write the effective address back to the base register.

A base field of zero selects the constant zero, not register zero. Displacement forms add the sign-extended displacement and indexed forms add the index register. Update forms return the address for base writeback. Halfword stores take the low 16 bits of the source. One indexed word form writes the source with its byte order reversed. An operation that cannot be carried out is still passed downstream, but it is marked as an error and has all enables cleared.

Results are held in a single output register behind a valid/ready handshake. There is one cycle of latency, and the block can accept one operation per cycle when the consumer is ready.

Top module: `store_fmt`

## Requirements
- R1: For displacement forms (op 0, 1, 4, 5), `out_addr` equals the base operand plus the sign-extended `disp`, modulo 2^32. The base operand is 0 when `base_is_zero` is 1 and `base_val` otherwise.
- R2: For indexed forms (op 2, 3, 6, 7, 8), `out_addr` equals the base operand (0 when `base_is_zero` is 1) plus `index_val`, modulo 2^32.
- R3: The update forms are op 1, 3, 5 and 7. When such an operation has a nonzero base field, `out_wb_en` is 1 and `out_addr` carries the value to write back. All other operations give `out_wb_en` = 0.
- R4: Halfword forms (op 4 to 7) place `src_val[15:0]` on lanes selected by address bit 1. When the bit is 0, `out_be` is 4'b1100 and `out_data` is {src[15:0], 16'h0}. When the bit is 1, `out_be` is 4'b0011 and `out_data` is {16'h0, src[15:0]}.
- R5: Plain word forms (op 0 to 3) give `out_be` = 4'b1111 and `out_data` = `src_val`.
- R6: The byte-reversed word form (op 8) gives `out_be` = 4'b1111 and `out_data` = {src[7:0], src[15:8], src[23:16], src[31:24]}.
- R7: An operation is an error if its op code is 9 to 15, or if it is an update form with `base_is_zero` = 1. An error gives `out_err` = 1, `out_be` = 0 and `out_wb_en` = 0. A valid result has `out_err` = 0.
- R8: `in_ready` equals `!out_valid || out_ready`. An operation accepted at a clock edge is presented with `out_valid` = 1 after that edge. While `out_valid` is 1 and `out_ready` is 0, all outputs stay unchanged.
- R9: During and after reset, `out_valid` is 0 until an operation is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Block can accept an operation |
| op | input | 4 | Store operation code |
| base_val | input | 32 | Base register value |
| base_is_zero | input | 1 | Base register field is zero |
| index_val | input | 32 | Index register value |
| disp | input | 16 | Signed displacement |
| src_val | input | 32 | Source register value |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 32 | Effective address and writeback value |
| out_be | output | 4 | Byte enables, bit 3 = lowest address |
| out_data | output | 32 | Lane-aligned write data |
| out_wb_en | output | 1 | Write `out_addr` back to the base register |
| out_err | output | 1 | Operation is invalid |

## Verification
Some properties are checked by assertions on every cycle. While `out_valid` is 1 and `out_ready` is 0, the outputs must not change. An accepted operation must appear on the next cycle. An error result must have no enables and no writeback. A valid result must use one of the three permitted enable patterns, and its unused data lanes must be zero. Other behaviour can only be shown by the bench's scenarios, which compare every result with a reference model. These cover address arithmetic with wrap and negative displacements, the rule that a zero base field means zero, byte reversal, and lane selection by address bit 1.

// File: rtl/store_fmt.sv
module store_fmt #(
  parameter int AW    = 32,
  parameter int DISPW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [3:0]    op,
  input  logic [AW-1:0] base_val,
  input  logic          base_is_zero,
  input  logic [AW-1:0] index_val,
  input  logic [DISPW-1:0] disp,
  input  logic [31:0]   src_val,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic [3:0]    out_be,
  output logic [31:0]   out_data,
  output logic          out_wb_en,
  output logic          out_err
);
  localparam int EXTW = AW - DISPW;

  wire is_brev = (op == 4'd8);
  wire legal   = !op[3] || is_brev;
  wire is_half = !op[3] && op[2];
  wire is_idx  = (!op[3] && op[1]) || is_brev;
  wire is_upd  = !op[3] && op[0];
  wire bad     = !legal || (is_upd && base_is_zero);

  wire [AW-1:0] base_eff = base_is_zero ? '0 : base_val;
  wire [AW-1:0] offset   = is_idx ? index_val : {{EXTW{disp[DISPW-1]}}, disp};
  wire [AW-1:0] ea       = base_eff + offset;

  logic [3:0]  be_n;
  logic [31:0] data_n;

  always_comb begin
    be_n   = 4'b1111;
    data_n = src_val;
    if (is_brev) begin
      data_n = {src_val[7:0], src_val[15:8], src_val[23:16], src_val[31:24]};
    end else if (is_half) begin
      if (ea[1]) begin
        be_n   = 4'b0011;
        data_n = {16'h0, src_val[15:0]};
      end else begin
        be_n   = 4'b1100;
        data_n = {src_val[15:0], 16'h0};
      end
    end
    if (bad) be_n = 4'b0000;
  end

  assign in_ready = !out_valid || out_ready;
  wire take = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_be    <= '0;
      out_data  <= '0;
      out_wb_en <= 1'b0;
      out_err   <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_addr  <= ea;
      out_be    <= be_n;
      out_data  <= data_n;
      out_wb_en <= is_upd && !bad;
      out_err   <= bad;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_data)
      && $stable(out_be) && $stable(out_wb_en) && $stable(out_err)); // R8
  AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R8
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> out_be == 4'b0000 && !out_wb_en); // R7
  AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_err |-> out_be == 4'b1111 || out_be == 4'b1100 || out_be == 4'b0011); // R4
  AST_HALF_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_be == 4'b1100 |-> out_data[15:0] == 16'h0 && !out_addr[1]); // R4
  AST_HALF_LANES_HI: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_be == 4'b0011 |-> out_data[31:16] == 16'h0 && out_addr[1]); // R4
endmodule

// File: tb/store_fmt_bench.sv
module store_fmt_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  op = '0;
  logic [31:0] base_val = '0;
  logic        base_is_zero = 1'b0;
  logic [31:0] index_val = '0;
  logic [15:0] disp = '0;
  logic [31:0] src_val = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_addr;
  logic [3:0]  out_be;
  logic [31:0] out_data;
  logic        out_wb_en;
  logic        out_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  store_fmt u_store_fmt (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op(op), .base_val(base_val), .base_is_zero(base_is_zero),
    .index_val(index_val), .disp(disp), .src_val(src_val),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_be(out_be), .out_data(out_data), .out_wb_en(out_wb_en), .out_err(out_err)
  );

  // expected: {err, wb, be[3:0], data[31:0], addr[31:0]}
  function automatic logic [69:0] model(input logic [3:0] o, input logic [31:0] b,
      input logic bz, input logic [31:0] x, input logic [15:0] d, input logic [31:0] s);
    logic [31:0] a, dat;
    logic [3:0] be;
    logic err, wb, upd;
    a   = (bz ? 32'h0 : b) + ((o == 4'd8 || (o < 4'd8 && (o & 4'd2) != 0)) ? x
          : {{16{d[15]}}, d});
    upd = (o < 4'd8) && (o & 4'd1) != 0;
    err = (o > 4'd8) || (upd && bz);
    wb  = upd && !err;
    be  = 4'b1111;
    dat = s;
    if (o == 4'd8) dat = {s[7:0], s[15:8], s[23:16], s[31:24]};
    else if (o >= 4'd4 && o < 4'd8) begin
      be  = a[1] ? 4'b0011 : 4'b1100;
      dat = a[1] ? {16'h0, s[15:0]} : {s[15:0], 16'h0};
    end
    if (err) be = 4'b0000;
    return {err, wb, be, dat, a};
  endfunction

  task automatic check(input string tag, input logic [69:0] got, input logic [69:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] o, input logic bz);
    if (o > 4'd8 || (o < 4'd8 && o[0] && bz)) return "R7";
    if (o == 4'd8) return "R6/R2";
    if (o >= 4'd4) return o[0] ? "R4/R3" : "R4";
    return o[1] ? "R5/R2" : (o[0] ? "R5/R1/R3" : "R5/R1");
  endfunction

  function automatic logic [69:0] got_vec();
    return {out_err, out_wb_en, out_be, out_data, out_addr};
  endfunction

  task automatic run_one(input logic [3:0] o, input logic [31:0] b, input logic bz,
      input logic [31:0] x, input logic [15:0] d, input logic [31:0] s);
    @(negedge clk);
    op = o; base_val = b; base_is_zero = bz; index_val = x; disp = d; src_val = s;
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    checks++;
    if (out_valid !== 1'b1) begin
      errors++;
      $display("FAIL R8: out_valid got %b expected 1", out_valid);
    end
    check(tag_of(o, bz), got_vec(), model(o, b, bz, x, d, s));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [69:0] held;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R9: out_valid/in_ready got %b%b expected 01", out_valid, in_ready);
    end
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R9: out_valid got %b expected 0", out_valid);
    end

    // directed corners
    run_one(4'd0, 32'hFFFF_FFFE, 1'b0, 32'h0, 16'h0004, 32'hCAFE_F00D); // R1 wrap
    run_one(4'd0, 32'h0000_0100, 1'b0, 32'h0, 16'hFFF0, 32'h1);         // R1 negative
    run_one(4'd4, 32'hDEAD_BEEF, 1'b1, 32'h0, 16'h0012, 32'hAAAA_1234); // R1 zero base, R4 hi lanes
    run_one(4'd6, 32'h0000_1000, 1'b0, 32'h2, 16'h0, 32'h5555_BEEF);    // R2, R4 addr[1]=1
    run_one(4'd8, 32'h0000_2000, 1'b0, 32'h10, 16'h0, 32'h1122_3344);   // R6
    run_one(4'd3, 32'h0000_0040, 1'b0, 32'h8, 16'h0, 32'h9);            // R3
    run_one(4'd5, 32'h0000_0040, 1'b1, 32'h8, 16'h0002, 32'h9);         // R7 update zero base
    run_one(4'd12, 32'h0000_0040, 1'b0, 32'h8, 16'h0002, 32'h9);        // R7 bad code
    run_one(4'd2, 32'hFFFF_FFFF, 1'b0, 32'h1, 16'h0, 32'h7);            // R2 wrap

    // backpressure: R8
    @(negedge clk);
    op = 4'd1; base_val = 32'h100; base_is_zero = 1'b0; disp = 16'h4; src_val = 32'hA5A5_5A5A;
    in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    held = model(4'd1, 32'h100, 1'b0, 32'h0, 16'h4, 32'hA5A5_5A5A);
    op = 4'd0; base_val = 32'h300; disp = 16'h8; src_val = 32'h0BAD_0BAD;
    checks++;
    if (in_ready !== 1'b0) begin
      errors++;
      $display("FAIL R8: in_ready got %b expected 0", in_ready);
    end
    check("R8 first", got_vec(), held);
    @(negedge clk);
    check("R8 held", got_vec(), held);
    out_ready = 1'b1;
    #1;
    checks++;
    if (in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R8: in_ready got %b expected 1", in_ready);
    end
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 next", got_vec(), model(4'd0, 32'h300, 1'b0, 32'h0, 16'h8, 32'h0BAD_0BAD));
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R8: out_valid got %b expected 0", out_valid);
    end

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [3:0] o;
      o = ($urandom % 5 == 0) ? 4'($urandom % 16) : 4'($urandom % 9);
      run_one(o, $urandom, ($urandom % 4 == 0), $urandom, 16'($urandom), $urandom);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule